// File: doc/BRIEF.md
# Bipolar Line Code Decoder with Violation Flag

This block sits behind a T1/E1 line receiver. Each bit period it takes the recovered positive-rail and negative-rail pulses and removes the zero-substitution codes that the far end inserted. The substitution code is B8ZS or HDB3, or no decoding at all, as a two-bit code select chooses. The decoded stream goes to the framer in one of two forms. The first is a single unipolar data line. The second is the two bipolar rails. In unipolar form a violation flag comes out beside the data, aligned to the bit it concerns.

The decoder holds the last eight received symbols in a window. A substitution can therefore be recognised in full before its first symbol leaves. The block runs on the recovered clock, and a clock enable marks the valid bit periods. Polarity history runs over the raw symbols, including those that a substitution later blanks. In E1 operation, with the extra-reporting enable set and HDB3 selected, the flag also marks two things. The first is substitutions that break the alternation of violation pulses. The second is any run of four zero symbols, which a correct HDB3 transmitter never sends.

Top module: `line_code_decoder`

## Requirements
- R1: A symbol sampled on one enabled clock edge appears on the registered outputs right after the eighth enabled edge that follows it.
- R2: `code_sel` encodes 2'b00 no decoding, 2'b01 B8ZS, 2'b10 HDB3 and 2'b11 no decoding; with no decoding, every symbol passes unchanged.
- R3: With B8ZS selected and P the polarity of the last single-rail pulse, the eight symbols 0,0,0,P,not-P,0,not-P,P (oldest first) are output as eight zeros and raise no flag.
- R4: With HDB3 selected, the four symbols 0,0,0,P or not-P,0,0,not-P (oldest first) are output as four zeros; the last of the four is the substitution's V pulse.
- R5: In unipolar mode, a single-rail pulse outside a substitution raises `viol` on its output bit when its polarity equals that of the previous single-rail pulse; after reset the previous pulse is taken as negative, and blanked pulses still update the history.
- R6: A symbol with pulses on both rails is output as a one, raises `viol` in unipolar mode, and leaves the polarity history unchanged.
- R7: In unipolar mode `dout_pos` carries the decoded data (1 = pulse) and `dout_neg` stays 0; in bipolar mode the two rails carry the decoded pulses and `viol` stays 0.
- R8: With `e1_viol_en` set, HDB3 selected and unipolar mode, a recognised substitution whose V pulse has the same polarity as the previous substitution's V pulse raises `viol` on its first (zero) output bit; the first substitution after reset is never flagged.
- R9: Under the same conditions as R8, four zero symbols in a row outside a substitution raise `viol` on the output bit of the first of them.
- R10: While `ce` is low, no state changes and all outputs hold their values.
- R11: A synchronous reset clears the window and outputs to zero, the substitution state, and the V-pulse history, and sets the last pulse polarity to negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable, one bit period per enabled edge |
| code_sel | input | 2 | 00 none, 01 B8ZS, 10 HDB3, 11 none |
| uni_sel | input | 1 | 1 = unipolar output, 0 = bipolar rails |
| e1_viol_en | input | 1 | Enables code and zero-substitution violation reporting under HDB3 |
| rx_pos | input | 1 | Received positive-rail pulse |
| rx_neg | input | 1 | Received negative-rail pulse |
| dout_pos | output | 1 | Unipolar data, or decoded positive rail |
| dout_neg | output | 1 | Decoded negative rail, 0 in unipolar mode |
| viol | output | 1 | Violation flag aligned to the output bit |

## Verification
Properly encoded random AMI, B8ZS and HDB3 streams at several pulse densities show that legal substitutions are fully blanked without false flags, in both output forms and under a gapped clock enable. A directed HDB3 sequence sets two substitutions with the same V polarity next to a bare four-zero run, a repeated-polarity pulse and a double-rail symbol. This separates code violations from zero-substitution violations and from plain bipolar violations. Random symbol soup under every code select, including the B8ZS patterns offered to the HDB3 decoder and the reverse, shows that each decoder matches only its own pattern. A reset in mid-stream confirms that polarity and V history restart from their defined state.

// File: rtl/line_code_decoder.sv
module line_code_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce,
  input  logic [1:0] code_sel,
  input  logic       uni_sel,
  input  logic       e1_viol_en,
  input  logic       rx_pos,
  input  logic       rx_neg,
  output logic       dout_pos,
  output logic       dout_neg,
  output logic       viol
);
  localparam int DEPTH = 8;
  localparam int OLD = DEPTH - 1;
  localparam int HOLD_W = $clog2(DEPTH);
  localparam logic [1:0] CODE_B8ZS = 2'b01;
  localparam logic [1:0] CODE_HDB3 = 2'b10;
  localparam logic [HOLD_W-1:0] B8_REST = HOLD_W'(DEPTH - 1);
  localparam logic [HOLD_W-1:0] HD_REST = HOLD_W'(DEPTH / 2 - 1);

  logic [DEPTH-1:0]  wp, wn, zr;
  logic [HOLD_W-1:0] hold;
  logic last_pos, v_seen, v_last_pos;
  logic idle, b8_hit, h_000v, h_b00v, h_hit, h_vpos, pass, e1_on;
  logic bpv, zsv, cv, dp, dn;

  function automatic logic pulse_of(input logic p, input logic n, input logic want_pos);
    return want_pos ? (p & ~n) : (n & ~p);
  endfunction

  assign zr    = ~(wp | wn);
  assign idle  = (hold == '0);
  assign e1_on = e1_viol_en && (code_sel == CODE_HDB3);

  assign b8_hit = idle && (code_sel == CODE_B8ZS) && zr[OLD] && zr[OLD-1] && zr[OLD-2]
                  && pulse_of(wp[OLD-3], wn[OLD-3], last_pos)
                  && pulse_of(wp[OLD-4], wn[OLD-4], ~last_pos)
                  && zr[OLD-5]
                  && pulse_of(wp[OLD-6], wn[OLD-6], ~last_pos)
                  && pulse_of(wp[OLD-7], wn[OLD-7], last_pos);

  assign h_000v = zr[OLD] && zr[OLD-1] && zr[OLD-2] && pulse_of(wp[OLD-3], wn[OLD-3], last_pos);
  assign h_b00v = pulse_of(wp[OLD], wn[OLD], ~last_pos) && zr[OLD-1] && zr[OLD-2]
                  && pulse_of(wp[OLD-3], wn[OLD-3], ~last_pos);
  assign h_hit  = idle && (code_sel == CODE_HDB3) && (h_000v || h_b00v);
  assign h_vpos = h_000v ? last_pos : ~last_pos;

  assign pass = idle && !b8_hit && !h_hit;
  assign bpv  = pass && ((wp[OLD] && wn[OLD]) || pulse_of(wp[OLD], wn[OLD], last_pos));
  assign zsv  = pass && e1_on && (&zr[OLD:OLD-3]);
  assign cv   = h_hit && e1_on && v_seen && (v_last_pos == h_vpos);
  assign dp   = pass && wp[OLD];
  assign dn   = pass && wn[OLD];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp         <= '0;
      wn         <= '0;
      hold       <= '0;
      last_pos   <= 1'b0;
      v_seen     <= 1'b0;
      v_last_pos <= 1'b0;
      dout_pos   <= 1'b0;
      dout_neg   <= 1'b0;
      viol       <= 1'b0;
    end else if (ce) begin
      wp <= {wp[DEPTH-2:0], rx_pos};
      wn <= {wn[DEPTH-2:0], rx_neg};
      if (wp[OLD] ^ wn[OLD]) last_pos <= wp[OLD];
      if (b8_hit)      hold <= B8_REST;
      else if (h_hit)  hold <= HD_REST;
      else if (!idle)  hold <= hold - 1'b1;
      if (h_hit) begin
        v_seen     <= 1'b1;
        v_last_pos <= h_vpos;
      end
      dout_pos <= uni_sel ? (dp | dn) : dp;
      dout_neg <= uni_sel ? 1'b0 : dn;
      viol     <= uni_sel && (bpv || zsv || cv);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !dout_pos && !dout_neg && !viol); // R11
  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(dout_pos) && $stable(dout_neg) && $stable(viol)); // R10
  AST_BIPOLAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ce && !uni_sel) |=> !viol); // R7
  AST_UNI_NEG_LOW: assert property (@(posedge clk) disable iff (rst)
    (ce && uni_sel) |=> !dout_neg); // R7
  AST_SUB_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (ce && !idle) |=> !dout_pos && !dout_neg); // R3
  AST_DOUBLE_ONE: assert property (@(posedge clk) disable iff (rst)
    (ce && uni_sel && idle && wp[OLD] && wn[OLD]) |=> dout_pos && viol); // R6
  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (ce && !uni_sel && idle && (code_sel == 2'b00 || code_sel == 2'b11))
    |=> (dout_pos == $past(wp[OLD])) && (dout_neg == $past(wn[OLD]))); // R2
endmodule

// File: tb/line_code_decoder_bench.sv
module line_code_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic [1:0] code_sel = 2'b00;
  logic uni_sel = 1'b1;
  logic e1_viol_en = 1'b0;
  logic rx_pos = 1'b0;
  logic rx_neg = 1'b0;
  logic dout_pos, dout_neg, viol;

  always #4 clk = ~clk;

  line_code_decoder u_line_code_decoder (
    .clk(clk), .rst(rst), .ce(ce), .code_sel(code_sel), .uni_sel(uni_sel),
    .e1_viol_en(e1_viol_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .dout_pos(dout_pos), .dout_neg(dout_neg), .viol(viol));

  int checks = 0;
  int errors = 0;
  bit started = 0;
  logic [1:0] stim[$];

  logic [1:0] mq[$];
  bit m_last_pos, m_vseen, m_vpos;
  int m_skip;
  logic e_pos = 0, e_neg = 0, e_viol = 0;
  string e_tag = "R11";

  function automatic logic [1:0] pl(input bit pos);
    return pos ? 2'b10 : 2'b01;
  endfunction

  task automatic model_step(input logic [1:0] sym);
    bit hit8, a000v, ab00v, e1a, bpv, zs, cv, op, on, vp;
    string tag;
    op = 0; on = 0; bpv = 0; zs = 0; cv = 0; vp = 0;
    e1a = e1_viol_en && (code_sel == 2'b10);
    hit8 = (code_sel == 2'b01) && mq[0] == 2'b00 && mq[1] == 2'b00 && mq[2] == 2'b00
           && mq[3] == pl(m_last_pos) && mq[4] == pl(!m_last_pos) && mq[5] == 2'b00
           && mq[6] == pl(!m_last_pos) && mq[7] == pl(m_last_pos);
    a000v = mq[0] == 2'b00 && mq[1] == 2'b00 && mq[2] == 2'b00 && mq[3] == pl(m_last_pos);
    ab00v = mq[0] == pl(!m_last_pos) && mq[1] == 2'b00 && mq[2] == 2'b00 && mq[3] == pl(!m_last_pos);
    if (m_skip > 0) begin
      m_skip--; tag = "R3/R4";
    end else if (hit8) begin
      m_skip = 7; tag = "R3";
    end else if (code_sel == 2'b10 && (a000v || ab00v)) begin
      vp = a000v ? m_last_pos : !m_last_pos;
      cv = e1a && m_vseen && (m_vpos == vp);
      m_vseen = 1; m_vpos = vp; m_skip = 3;
      tag = cv ? "R8" : "R4";
    end else begin
      op = mq[0][1]; on = mq[0][0];
      bpv = (op && on) || (op && !on && m_last_pos) || (on && !op && !m_last_pos);
      zs = e1a && mq[0] == 2'b00 && mq[1] == 2'b00 && mq[2] == 2'b00 && mq[3] == 2'b00;
      if (op && on) tag = "R6";
      else if (zs) tag = "R9";
      else if (bpv) tag = "R5";
      else if (!uni_sel) tag = "R7";
      else if (code_sel == 2'b00 || code_sel == 2'b11) tag = "R2";
      else tag = "R1";
    end
    if (mq[0][1] ^ mq[0][0]) m_last_pos = mq[0][1];
    if (uni_sel) begin
      e_pos = op | on; e_neg = 0; e_viol = bpv | zs | cv;
    end else begin
      e_pos = op; e_neg = on; e_viol = 0;
    end
    e_tag = tag;
    void'(mq.pop_front());
    mq.push_back(sym);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      repeat (8) mq.push_back(2'b00);
      m_last_pos = 0; m_vseen = 0; m_vpos = 0; m_skip = 0;
      e_pos = 0; e_neg = 0; e_viol = 0; e_tag = "R11";
      started = 1;
    end else if (ce) begin
      model_step({rx_pos, rx_neg});
    end else begin
      e_tag = "R10";
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if ({dout_pos, dout_neg, viol} !== {e_pos, e_neg, e_viol}) begin
        errors++;
        $display("FAIL %s: pos/neg/viol got %b%b%b expected %b%b%b at %0t",
                 e_tag, dout_pos, dout_neg, viol, e_pos, e_neg, e_viol, $time);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; ce = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic play(input int ce_pct);
    while (stim.size() > 0) begin
      @(negedge clk);
      if ($urandom_range(99) < ce_pct) begin
        ce = 1; {rx_pos, rx_neg} = stim.pop_front();
      end else begin
        ce = 0; {rx_pos, rx_neg} = 2'($urandom_range(3));
      end
    end
    @(negedge clk); ce = 0;
  endtask

  task automatic encode(input int nbits, input int dens, input int code);
    bit d[$];
    bit lp, run;
    int pulses, i, len;
    lp = 0; pulses = 0; i = 0;
    len = (code == 1) ? 8 : 4;
    for (int k = 0; k < nbits; k++) d.push_back($urandom_range(99) < dens);
    while (i < d.size()) begin
      run = 0;
      if (code != 0 && i + len <= d.size()) begin
        run = 1;
        for (int k = 0; k < len; k++) if (d[i+k]) run = 0;
      end
      if (run && code == 1) begin
        stim.push_back(2'b00); stim.push_back(2'b00); stim.push_back(2'b00);
        stim.push_back(pl(lp)); stim.push_back(pl(!lp)); stim.push_back(2'b00);
        stim.push_back(pl(!lp)); stim.push_back(pl(lp));
        i += 8;
      end else if (run) begin
        if (pulses % 2 == 1) begin
          stim.push_back(2'b00); stim.push_back(2'b00); stim.push_back(2'b00); stim.push_back(pl(lp));
        end else begin
          lp = !lp;
          stim.push_back(pl(lp)); stim.push_back(2'b00); stim.push_back(2'b00); stim.push_back(pl(lp));
        end
        pulses = 0; i += 4;
      end else if (d[i]) begin
        lp = !lp; stim.push_back(pl(lp)); pulses++; i++;
      end else begin
        stim.push_back(2'b00); i++;
      end
    end
  endtask

  task automatic soup(input int n);
    for (int k = 0; k < n; k++)
      stim.push_back(($urandom_range(1) == 0) ? 2'b00 : 2'($urandom_range(3)));
  endtask

  task automatic config_run(input logic [1:0] cs, input logic u, input logic e1);
    @(negedge clk); code_sel = cs; uni_sel = u; e1_viol_en = e1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset state
    do_reset();
    @(negedge clk);
    checks++;
    if ({dout_pos, dout_neg, viol} !== 3'b000) begin
      errors++;
      $display("FAIL R11: outputs got %b%b%b expected 000", dout_pos, dout_neg, viol);
    end
    // R2, R5: AMI with no decoding
    config_run(2'b00, 1, 0); do_reset(); encode(300, 50, 0); play(100);
    // R3: B8ZS, unipolar and bipolar, gapped enable (R10)
    config_run(2'b01, 1, 0); do_reset(); encode(400, 20, 1); play(70);
    config_run(2'b01, 0, 0); do_reset(); encode(400, 30, 1); play(80);
    // R4: HDB3, reporting off then on
    config_run(2'b10, 1, 0); do_reset(); encode(400, 25, 2); play(75);
    config_run(2'b10, 1, 1); do_reset(); encode(400, 35, 2); play(100);
    // R8, R9, R5, R6 directed: two same-polarity V substitutions, bare zeros, BPV, double
    config_run(2'b10, 1, 1); do_reset();
    stim = '{2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10,
             2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b11, 2'b01, 2'b01,
             2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00};
    play(100);
    // R2, R7: code 11 bypass on bipolar rails with arbitrary symbols
    config_run(2'b11, 0, 0); do_reset(); soup(300); play(90);
    // cross-decoding and random soup in every mode, with mid-run reset (R11)
    config_run(2'b10, 1, 1); do_reset(); encode(300, 20, 1); play(100);
    config_run(2'b01, 1, 1); do_reset(); encode(300, 20, 2); play(100);
    for (int m = 0; m < 4; m++) begin
      config_run(2'(m), 1'($urandom_range(1)), 1'($urandom_range(1)));
      do_reset(); soup(250); play(85);
      soup(100); fork play(85); begin repeat (40) @(negedge clk); rst = 1; @(negedge clk); rst = 0; end join
    end
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule